// File: doc/BRIEF.md
# Segmented Stream Reduction Unit

The unit reads a finite stream of signed 32-bit integers and folds every run of consecutive elements into one sum. The stream length `TOTAL_LEN` and the number of results `OUT_LEN` are parameters, and each group holds `TOTAL_LEN/OUT_LEN` elements. When a group holds the whole stream, the unit produces a single total. A one-cycle `start` pulse arms the unit. It then accepts exactly `TOTAL_LEN` elements and hands back exactly `OUT_LEN` sums. A one-cycle `done` pulse follows the acceptance of the last sum, and the unit then goes back to idle.

Both stream sides use valid/ready. An element moves only in a cycle where `in_valid` and `in_ready` are both high. A result moves only in a cycle where `out_valid` and `out_ready` are both high. A result that is offered stays on `out_data` unchanged until it is taken. The unit applies back-pressure upstream: while a result sits unaccepted and `out_ready` is low, `in_ready` stays low. A wrapping position counter tracks where the current element falls in its group, so no divider is needed. The first element of a group loads the accumulator, and the finished sum moves to the output register when the next group opens. After the final element, a flush step emits the last sum.

Top module: `seg_reduce_unit`

## Requirements
- R1: Result k (counting from 0) equals the sum of input elements k*G through k*G+G-1, where G = TOTAL_LEN/OUT_LEN. Results leave in increasing k order.
- R2: When OUT_LEN is 1, the unit emits a single result equal to the sum of all TOTAL_LEN elements.
- R3: Sums are 32-bit two's complement and wrap on overflow (modulo 2^32).
- R4: Group position runs from 0 to G-1 and returns to 0 after G-1. The first element of each group starts a fresh sum that carries nothing from the previous group.
- R5: An element is consumed only in a cycle with in_valid and in_ready both high. in_ready is low while the unit is idle.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged in the next cycle.
- R7: While a result is offered (out_valid high) and out_ready is low, in_ready is low.
- R8: done is high for exactly one cycle, the cycle after the OUT_LEN-th result is accepted. In that cycle and the following one, out_valid and in_ready are low.
- R9: After reset, out_valid, in_ready and done are low.
- R10: A start pulse that arrives while a stream is in progress has no effect. Every result of that stream still matches R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that arms the unit when idle |
| in_valid | input | 1 | Input element present |
| in_data | input | 32 | Signed input element |
| in_ready | output | 1 | Unit can take an element this cycle |
| out_valid | output | 1 | Result present |
| out_data | output | 32 | Signed group sum |
| out_ready | input | 1 | Downstream takes the result this cycle |
| done | output | 1 | One-cycle pulse after the last result is accepted |

## Verification
The bench uses four data patterns. A ramp exposes a group boundary placed one element off. Alternating-sign values expose a sum that leaks from one group into the next. Values next to the largest positive number force wrap-around. A scrambled sequence catches lanes that are swapped or dropped. Each pattern runs under every pairing of three input-gap schedules and three output-stall schedules. Long output stalls push results into the held state and check that the input side stops. Some runs carry a stray start pulse in the middle of the stream. A second instance, where one group covers the whole stream, checks the single-total case.

// File: rtl/seg_red_pkg.sv
package seg_red_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DRAIN = 2'd3
  } seg_state_t;
endpackage

// File: rtl/seg_pos_counter.sv
module seg_pos_counter #(
  parameter int GROUP = 4,
  localparam int PW = (GROUP > 1) ? $clog2(GROUP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  output logic [PW-1:0] pos,
  output logic          at_first
);
  localparam logic [PW-1:0] POS_LAST = PW'(GROUP - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos <= '0;
    else if (clear)
      pos <= '0;
    else if (advance) begin
      if (pos == POS_LAST)
        pos <= '0;
      else
        pos <= pos + 1'b1;
    end
  end

  assign at_first = (pos == '0);

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_LAST); // R4
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !clear) |=> $stable(pos)); // R4
endmodule

// File: rtl/seg_accum.sv
module seg_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         fresh,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc <= '0;
    else if (take)
      acc <= fresh ? din : (acc + din);
  end

  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(acc)); // R4
endmodule

// File: rtl/seg_out_slot.sv
module seg_out_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= push_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!out_valid || out_ready)); // R7
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
endmodule

// File: rtl/seg_reduce_unit.sv
module seg_reduce_unit
  import seg_red_pkg::*;
#(
  parameter int W         = 32,
  parameter int TOTAL_LEN = 12,
  parameter int OUT_LEN   = 3,
  localparam int GROUP    = TOTAL_LEN / OUT_LEN,
  localparam int PW       = (GROUP > 1) ? $clog2(GROUP) : 1,
  localparam int EW       = $clog2(TOTAL_LEN + 1),
  localparam int OW       = $clog2(OUT_LEN + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready,
  output logic         done
);
  if (OUT_LEN < 1 || TOTAL_LEN % OUT_LEN != 0) begin : g_bad_ratio
    $error("TOTAL_LEN must be a nonzero multiple of OUT_LEN");
  end

  seg_state_t       state;
  logic [EW-1:0]    elem_cnt;
  logic [OW-1:0]    out_cnt;
  logic [PW-1:0]    pos;
  logic             pos_first;
  logic [W-1:0]     acc;
  logic             accept_ok, in_fire, out_fire;
  logic             push_mid, push_flush, push;
  logic             last_elem, last_out, arm;

  assign arm        = (state == ST_IDLE) && start;
  assign accept_ok  = !out_valid || out_ready;
  assign in_ready   = (state == ST_RUN) && accept_ok;
  assign in_fire    = in_valid && in_ready;
  assign out_fire   = out_valid && out_ready;
  assign last_elem  = (elem_cnt == EW'(TOTAL_LEN - 1));
  assign last_out   = (out_cnt == OW'(OUT_LEN - 1));
  assign push_mid   = in_fire && pos_first && (elem_cnt != '0);
  assign push_flush = (state == ST_FLUSH) && accept_ok;
  assign push       = push_mid || push_flush;

  seg_pos_counter #(.GROUP(GROUP)) i_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (arm),
    .advance  (in_fire),
    .pos      (pos),
    .at_first (pos_first)
  );

  seg_accum #(.W(W)) i_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (in_fire),
    .fresh (pos_first),
    .din   (in_data),
    .acc   (acc)
  );

  seg_out_slot #(.W(W)) i_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (acc),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      elem_cnt <= '0;
      out_cnt  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (arm) begin
        elem_cnt <= '0;
        out_cnt  <= '0;
      end else begin
        if (in_fire)
          elem_cnt <= elem_cnt + 1'b1;
        if (out_fire)
          out_cnt <= out_cnt + 1'b1;
      end
      unique case (state)
        ST_IDLE:  if (start) state <= ST_RUN;
        ST_RUN:   if (in_fire && last_elem) state <= ST_FLUSH;
        ST_FLUSH: if (push_flush) state <= ST_DRAIN;
        ST_DRAIN: if (out_fire && last_out) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !in_ready); // R5
  AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !in_ready)); // R8
  AST_ELEM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    elem_cnt <= EW'(TOTAL_LEN)); // R5
endmodule

// File: tb/test_seg_reduce_unit.sv
module test_seg_reduce_unit;
  localparam int TL = 12;
  localparam int OL = 3;
  localparam int G  = TL / OL;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_ready = 1'b0;
  logic        done;

  logic        b_start = 1'b0;
  logic        b_in_valid = 1'b0;
  logic [31:0] b_in_data = '0;
  logic        b_in_ready;
  logic        b_out_valid;
  logic [31:0] b_out_data;
  logic        b_done;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  logic [31:0] elem [TL];
  logic [31:0] expv [OL];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seg_reduce_unit #(.W(32), .TOTAL_LEN(TL), .OUT_LEN(OL)) i_seg_reduce_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .done(done));

  seg_reduce_unit #(.W(32), .TOTAL_LEN(5), .OUT_LEN(1)) i_seg_reduce_unit_whole (
    .clk(clk), .rst_n(rst_n), .start(b_start), .in_valid(b_in_valid),
    .in_data(b_in_data), .in_ready(b_in_ready), .out_valid(b_out_valid),
    .out_data(b_out_data), .out_ready(1'b1), .done(b_done));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(input int p, input int i);
    case (p)
      0: return 32'(i + 1);
      1: return (i % 2 == 1) ? -32'(i * 7) : 32'(i * 13);
      2: return 32'h7fff_ffff - 32'(i % 2);
      default: return (32'(i) * 32'h9e37_79b1) ^ 32'(i << 3);
    endcase
  endfunction

  task automatic run_stream(input int p, input int vm, input int rm, input bit stray);
    for (int i = 0; i < TL; i++) elem[i] = gen(p, i);
    for (int k = 0; k < OL; k++) begin
      expv[k] = '0;
      for (int j = 0; j < G; j++) expv[k] = expv[k] + elem[k * G + j];
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    fork
      begin : producer
        int idx = 0;
        while (idx < TL) begin
          @(negedge clk);
          start    = stray && (idx == 5);
          in_valid = (vm == 0) || (vm == 1 && cyc % 2 == 0) || (vm == 2 && cyc % 3 != 0);
          in_data  = elem[idx];
          #1;
          if (in_valid && in_ready) idx++;
        end
        @(negedge clk); in_valid = 1'b0; start = 1'b0;
      end
      begin : consumer
        int k = 0;
        bit held = 0;
        logic [31:0] hval = '0;
        while (k < OL) begin
          @(negedge clk);
          out_ready = (rm == 0) || (rm == 1 && cyc % 2 == 1) || (rm == 2 && cyc % 4 == 3);
          #1;
          if (held) check(out_valid && out_data == hval, "R6 hold", out_data, hval);
          if (out_valid && !out_ready) begin
            held = 1; hval = out_data;
            check(!in_ready, "R7 in_ready while stalled", 32'(in_ready), 0);
          end else held = 0;
          if (out_valid && out_ready) begin
            // R1/R4 group sums; R3 wrap for pattern 2; R10 stray start runs
            check(out_data == expv[k], "R1/R4/R3/R10 group sum", out_data, expv[k]);
            k++;
          end
        end
        @(negedge clk); out_ready = 1'b0; #1;
        check(done == 1'b1, "R8 done pulse", 32'(done), 1);
        check(!out_valid && !in_ready, "R8 quiet at done", 32'({out_valid, in_ready}), 0);
        @(negedge clk); #1;
        check(done == 1'b0, "R8 done one cycle", 32'(done), 0);
        check(!in_ready && !out_valid, "R8/R5 idle after done", 32'({out_valid, in_ready}), 0);
      end
    join
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !in_ready && !done, "R9 reset state",
          32'({out_valid, in_ready, done}), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check(!in_ready, "R5 idle not ready", 32'(in_ready), 0);
    for (int p = 0; p < 4; p++)
      for (int vm = 0; vm < 3; vm++)
        for (int rm = 0; rm < 3; rm++)
          run_stream(p, vm, rm, (p + vm + rm) % 2 == 1);
    // R2: whole stream folds to one total on the second instance
    begin
      logic [31:0] vals [5];
      logic [31:0] sum = '0;
      int idx = 0;
      bit got = 0;
      vals[0] = -32'd3; vals[1] = 32'd10; vals[2] = 32'd100;
      vals[3] = -32'd50; vals[4] = 32'd7;
      for (int i = 0; i < 5; i++) sum = sum + vals[i];
      @(negedge clk); b_start = 1'b1;
      @(negedge clk); b_start = 1'b0;
      while (!got) begin
        @(negedge clk);
        b_in_valid = (idx < 5);
        b_in_data  = (idx < 5) ? vals[idx] : '0;
        #1;
        if (b_in_valid && b_in_ready) idx++;
        if (b_out_valid) begin
          got = 1;
          check(b_out_data == sum, "R2 single total", b_out_data, sum);
          check(idx == 5, "R2 all elements consumed", 32'(idx), 5);
        end
      end
      @(negedge clk); b_in_valid = 1'b0; #1;
      check(b_done == 1'b1, "R2 done after single result", 32'(b_done), 1);
      @(negedge clk); #1;
      check(!b_out_valid, "R2 only one result", 32'(b_out_valid), 0);
    end
    finish_run();
  end
endmodule